// File: doc/BRIEF.md
# Power-Mode and Clock-Source Controller

This controller keeps track of the operating power mode of a small processor. On every cycle it decides which of three clock sources drives the system: primary, secondary oscillator or internal oscillator block. It also decides whether the CPU clock enable and the peripheral clock enable are asserted. Software writes an 8-bit control register. One bit in that register selects idle behaviour and a 2-bit field selects the clock source. A one-cycle sleep-request strobe moves the processor out of Run, and a wake event brings it back.

The register bit and the mode state combine into seven modes. In Sleep every clock is stopped. In Run, on each of the three sources, the CPU and the peripherals are clocked. In Idle, on each of the three sources, only the peripherals are clocked. A source change never selects an oscillator that is not running. Such a change stays pending until that oscillator reports ready. A sleep request that arrives during a pending change is deferred until the change completes.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After reset the control register is 0x00, `src_sel` is 0, `mode` is 1 (primary Run), and both `cpu_clk_en` and `per_clk_en` are 1.
- R2: Bit 7 of the control register is the idle-select bit and bits 1:0 are the source field. Field value 00 gives `src_sel`=0 (primary), 01 gives 1 (secondary), and both 10 and 11 give 2 (internal).
- R3: A write whose target source has its `src_ready` bit high (bit 0 primary, bit 1 secondary, bit 2 internal) changes `src_sel` at the clock edge that captures the write. The Run or Idle variant in `mode` follows the new source.
- R4: If the target source is not ready, `src_sel` keeps the current source. The switch completes at the first clock edge at which that source's ready bit is high.
- R5: `mode` is encoded as 0 for Sleep, 1/2/3 for Run on primary/secondary/internal, and 4/5/6 for the matching Idle modes. A `sleep_req` in Run with idle-select 1 enters Idle (`cpu_clk_en`=0, `per_clk_en`=1). With idle-select 0 it enters Sleep (both enables 0).
- R6: When the idle-select bit already holds the desired value, a `sleep_req` alone reaches the target mode, with no register write in between.
- R7: A `wake_evt` in Idle returns to the Run mode of the current source on the next edge.
- R8: A `wake_evt` in Sleep re-enables the clocks only at an edge where the selected source's ready bit is high. Until then `mode` stays 0 and both enables stay 0.
- R9: A `sleep_req` during a pending switch leaves the block in Run until the switch completes, then takes effect. It uses the idle-select value captured at the strobe, even if the bit is rewritten in the meantime.
- R10: `wake_evt` while in Run and `sleep_req` while in Idle or Sleep have no effect.
- R11: `cpu_clk_en` is never high while `per_clk_en` is low, and `mode` never takes the value 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| sleep_req | input | 1 | One-cycle sleep request strobe |
| wake_evt | input | 1 | Wake event |
| src_ready | input | 3 | Ready flags: bit 0 primary, bit 1 secondary, bit 2 internal |
| src_sel | output | 2 | Active source code (0 primary, 1 secondary, 2 internal) |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| mode | output | 3 | Encoded current mode |

## Verification
The assertions check the following on every cycle. The CPU enable never runs without the peripheral enable. The mode code stays legal. Every change of the active source lands on a source that was ready. Clocks come back on only with a ready source. An Idle mode always shows the CPU stopped and the peripherals running. A CPU stop always follows a sleep strobe, either a direct one or a deferred one. Some behaviour only the bench's scenarios can show, because it depends on ordering: the pending switch that waits for readiness, the deferred sleep that keeps its captured idle bit after a rewrite, the Sleep wake that is held back by a missing ready flag, and the inputs that must be ignored.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } pm_state_t;

  localparam int SRC_W = 2;
  localparam int NSRC  = 3;
  localparam int MODE_W = 3;

  // Source field -> active source code: 00 primary, 01 secondary, 1x internal.
  function automatic logic [SRC_W-1:0] src_decode(input logic [1:0] fld);
    if (fld[1]) return 2'd2;
    return {1'b0, fld[0]};
  endfunction

  // State and source -> mode code: 0 sleep, 1..3 run, 4..6 idle.
  function automatic logic [MODE_W-1:0] mode_code(input pm_state_t st,
                                                  input logic [SRC_W-1:0] src);
    case (st)
      ST_RUN:  return 3'd1 + {1'b0, src};
      ST_IDLE: return 3'd4 + {1'b0, src};
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/pm_ctl_reg.sv
module pm_ctl_reg #(
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [CTL_W-1:0] ctl_next
);

  assign ctl_next = we ? wdata : ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_next;
  end

endmodule

// File: rtl/pm_src_switch.sv
module pm_src_switch
  import pwrmode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] req_src,
  input  logic [NSRC-1:0]  src_ready,
  output logic [SRC_W-1:0] act_src,
  output logic             pend_next,
  output logic             req_ready
);

  logic [SRC_W-1:0] act_next;

  assign req_ready = src_ready[req_src];
  assign act_next  = (req_src != act_src && req_ready) ? req_src : act_src;
  assign pend_next = (act_next != req_src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_src <= '0;
    else        act_src <= act_next;
  end

endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import pwrmode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      wake_evt,
  input  logic      idle_sel,
  input  logic      pend_next,
  input  logic      req_ready,
  output pm_state_t state,
  output logic      sleep_pend,
  output logic      enter_low
);

  pm_state_t state_n;
  logic      pend_n;
  logic      cap_idle, cap_idle_n;
  logic      use_idle;

  assign use_idle  = sleep_req ? idle_sel : cap_idle;
  assign enter_low = (state == ST_RUN) && (sleep_req || sleep_pend) && !pend_next;

  always_comb begin
    state_n    = state;
    pend_n     = sleep_pend;
    cap_idle_n = cap_idle;
    case (state)
      ST_RUN: begin
        if (enter_low) begin
          state_n = use_idle ? ST_IDLE : ST_SLEEP;
          pend_n  = 1'b0;
        end else if (sleep_req) begin
          pend_n     = 1'b1;
          cap_idle_n = idle_sel;
        end
      end
      ST_IDLE:  if (wake_evt) state_n = ST_RUN;
      ST_SLEEP: if (wake_evt) state_n = req_ready ? ST_RUN : ST_WAKE;
      ST_WAKE:  if (req_ready) state_n = ST_RUN;
      default:  state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      sleep_pend <= 1'b0;
      cap_idle   <= 1'b0;
    end else begin
      state      <= state_n;
      sleep_pend <= pend_n;
      cap_idle   <= cap_idle_n;
    end
  end

endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int CTL_W    = 8,
  parameter int IDLE_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             sleep_req,
  input  logic             wake_evt,
  input  logic [2:0]       src_ready,
  output logic [1:0]       src_sel,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic [2:0]       mode
);

  logic [CTL_W-1:0] ctl_q, ctl_next;
  logic [SRC_W-1:0] req_src, act_src;
  logic             pend_next_w, req_ready_w;
  logic             sleep_pend_w, enter_low_w;
  pm_state_t        state;

  pm_ctl_reg #(.CTL_W(CTL_W)) i_reg (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .ctl_q(ctl_q), .ctl_next(ctl_next)
  );

  assign req_src = src_decode(ctl_next[1:0]);

  pm_src_switch i_sw (
    .clk(clk), .rst_n(rst_n), .req_src(req_src), .src_ready(src_ready),
    .act_src(act_src), .pend_next(pend_next_w), .req_ready(req_ready_w)
  );

  pm_mode_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
    .idle_sel(ctl_q[IDLE_BIT]), .pend_next(pend_next_w), .req_ready(req_ready_w),
    .state(state), .sleep_pend(sleep_pend_w), .enter_low(enter_low_w)
  );

  assign src_sel    = act_src;
  assign cpu_clk_en = (state == ST_RUN);
  assign per_clk_en = (state == ST_RUN) || (state == ST_IDLE);
  assign mode       = mode_code(state, act_src);

endmodule

// File: rtl/pm_checker.sv
module pm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic [2:0] src_ready,
  input logic [1:0] src_sel,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic [2:0] mode,
  input logic       sleep_pend
);

  assert_cpu_needs_per_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> per_clk_en);

  assert_mode_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 3'd7);

  assert_switch_to_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != $past(src_sel)) |-> ((($past(src_ready) >> src_sel) & 3'b001) != 3'b000));

  assert_rise_needs_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_clk_en) |-> ((($past(src_ready) >> src_sel) & 3'b001) != 3'b000));

  assert_idle_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode >= 3'd4) |-> (per_clk_en && !cpu_clk_en));

  assert_cpu_stop_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk_en) |-> ($past(sleep_req) || $past(sleep_pend)));

endmodule

bind pwrmode_ctrl pm_checker i_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .src_ready(src_ready),
  .src_sel(src_sel), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .mode(mode), .sleep_pend(sleep_pend_w)
);

// File: tb/test_pwrmode_ctrl.sv
`timescale 1ns/100ps
module test_pwrmode_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       sleep_req = 1'b0;
  logic       wake_evt = 1'b0;
  logic [2:0] src_ready = 3'b111;
  logic [1:0] src_sel;
  logic       cpu_clk_en, per_clk_en;
  logic [2:0] mode;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pwrmode_ctrl i_pwrmode_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sleep_req(sleep_req), .wake_evt(wake_evt), .src_ready(src_ready),
    .src_sel(src_sel), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .mode(mode)
  );

  // Expected mode code: kind 0 sleep, 1 run, 2 idle.
  function automatic logic [2:0] want_mode(input int kind, input int src);
    if (kind == 1) return 3'(1 + src);
    if (kind == 2) return 3'(4 + src);
    return 3'd0;
  endfunction

  task automatic expect_all(input string req, input int kind, input int src);
    logic [2:0] m;
    logic c, p;
    m = want_mode(kind, src);
    c = (kind == 1);
    p = (kind != 0);
    n_chk++;
    if (mode !== m || cpu_clk_en !== c || per_clk_en !== p ||
        (kind != 0 && src_sel !== 2'(src))) begin
      n_bad++;
      $display("FAIL %s: mode=%0d cpu=%0b per=%0b src=%0d expected mode=%0d cpu=%0b per=%0b src=%0d",
               req, mode, cpu_clk_en, per_clk_en, src_sel, m, c, p, src);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    ctl_we = 1'b1; ctl_wdata = d;
    tick();
    ctl_we = 1'b0;
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1; tick(); sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_evt = 1'b1; tick(); wake_evt = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    expect_all("R1 reset state", 1, 0);
  endtask

  task automatic t_switch_ready();
    src_ready = 3'b111;
    wr(8'h01); expect_all("R3 switch to secondary", 1, 1);
    wr(8'h03); expect_all("R2 field 11 internal", 1, 2);
    wr(8'h02); expect_all("R2 field 10 internal", 1, 2);
    wr(8'h00); expect_all("R2 field 00 primary", 1, 0);
  endtask

  task automatic t_switch_pending();
    src_ready = 3'b001;
    wr(8'h01); expect_all("R4 held on primary", 1, 0);
    repeat (3) tick();
    expect_all("R4 still held", 1, 0);
    src_ready = 3'b011;
    tick();
    expect_all("R4 completes when ready", 1, 1);
    src_ready = 3'b111;
  endtask

  task automatic t_idle_cycle();
    wr(8'h81); expect_all("R2 idle bit write stays run", 1, 1);
    pulse_sleep(); expect_all("R5 idle entry", 2, 1);
    pulse_sleep(); expect_all("R10 sleep strobe in idle ignored", 2, 1);
    pulse_wake(); expect_all("R7 wake from idle", 1, 1);
    pulse_sleep(); expect_all("R6 strobe alone reaches idle", 2, 1);
    pulse_wake(); expect_all("R7 second wake", 1, 1);
  endtask

  task automatic t_sleep_cycle();
    wr(8'h02); expect_all("R3 internal run", 1, 2);
    pulse_wake(); expect_all("R10 wake in run ignored", 1, 2);
    pulse_sleep(); expect_all("R5 sleep entry", 0, 2);
    pulse_sleep(); expect_all("R10 sleep strobe in sleep ignored", 0, 2);
    src_ready = 3'b011;
    pulse_wake(); expect_all("R8 wake waits for ready", 0, 2);
    tick(); expect_all("R8 still waiting", 0, 2);
    src_ready = 3'b111;
    tick(); expect_all("R8 clocks back on ready", 1, 2);
  endtask

  task automatic t_deferred_sleep();
    src_ready = 3'b110;
    wr(8'h80); expect_all("R4 pending to primary", 1, 2);
    pulse_sleep(); expect_all("R9 strobe deferred", 1, 2);
    wr(8'h00); expect_all("R9 still run after rewrite", 1, 2);
    src_ready = 3'b111;
    tick(); expect_all("R9 captured idle bit used", 2, 0);
    wr(8'h01); expect_all("R3 idle variant follows source", 2, 1);
    pulse_wake(); expect_all("R7 wake to secondary run", 1, 1);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_switch_ready();
    t_switch_pending();
    t_idle_cycle();
    t_sleep_cycle();
    t_deferred_sleep();
    repeat (2) tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule